// File: doc/BRIEF.md
# Picture-in-picture window inserter

This block generates the timing that places a reduced sub-picture inside the main raster. It counts main-picture pixels from the horizontal strobe and lines from the vertical strobe, compares both counts with a programmed window origin and size, and drives a window switch, a border select, a fill select with its colour levels, and read addresses for a sub-picture field memory that sits outside the block. Every clock cycle is one main-picture pixel.

Width and height are picked independently: each can be the large (one-ninth screen) or the small (one-sixteenth screen) size. A one-pixel border can be drawn around the window in either the fill colour or its own colour. A background fill, or a mute, replaces the picture content with programmed levels. A freeze control stops sub-picture field writes while display reads go on. When the previous field was long, which marks a 50 Hz main picture, an optional mode scales the vertical origin by 1.2. All settings are captured on the vertical strobe, so each field is drawn with a single consistent set.

A small field state machine sequences the line count. Its states are `FS_WAIT_VD` (after reset, no field seen yet), `FS_ARMED` (vertical strobe seen, waiting for the first line strobe) and `FS_ACTIVE` (lines being counted). Its transitions are: WAIT_VD to ARMED on a vertical strobe; ARMED to ACTIVE on a line strobe; ACTIVE back to ARMED on a vertical strobe. A vertical and a line strobe together go straight to ACTIVE with line 0. Line strobes in WAIT_VD are ignored.

Top module: `pip_window_inserter`

## Requirements
- R1: After reset every output is 0, and line strobes that arrive before the first vertical strobe never open the window.
- R2: The pixel index is the number of clocks since the last `main_hd` strobe (the clock after the strobe edge is pixel 0). The line index is the number of `main_hd` strobes since `main_vd` (the first is line 0). The two counts stop at H_ACTIVE and V_ACTIVE, and nothing is drawn beyond them. Outputs for a pixel appear one clock after that pixel.
- R3: The picture area spans columns hpos to hpos+W-1 and rows vorg to vorg+H-1. W is WID_L when `size_h_small`=0 and WID_S when it is 1. H is HGT_L or HGT_S, chosen by `size_v_small` in the same way and independently.
- R4: `pip_sw` is 1 on the picture area and on the border when `disp_en` is set. With `disp_en`=0, all window outputs stay 0.
- R5: With `frame_en`=1, `border_sel` marks the one-pixel ring just outside the picture area (columns hpos-1 and hpos+W, rows vorg-1 and vorg+H, corners included). It is never set together with `fill_sel`.
- R6: On the border, `out_y/out_by/out_ry` carry the frame levels when `frame_own_color`=1 and the fill levels when it is 0. On the filled picture area they carry the fill levels. Elsewhere they are 0.
- R7: `fill_sel` is 1 on the picture area when `bg_en` or `mute` is 1.
- R8: `rd_en` is 1 on the displayed picture area, with `rd_x`=column-hpos and `rd_y`=row-vorg. Both addresses are 0 wherever `rd_en` is 0. The fill settings do not change them.
- R9: vorg equals vpos, except when `vpos_rescale`=1 and the field that just ended held more than RATE_SPLIT line strobes. In that case vorg is floor(vpos*6/5).
- R10: A window that extends past the active line or field is cut off at that edge and does not wrap.
- R11: All settings are captured on `main_vd`, and changes made during a field have no effect until the next `main_vd`.
- R12: `mem_wr_en` equals the `moving` value captured on `main_vd`. Display reads are not affected by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | active-low asynchronous reset |
| main_hd | input | 1 | main line strobe, one clock wide |
| main_vd | input | 1 | main field strobe, one clock wide |
| disp_en | input | 1 | show the window |
| size_h_small | input | 1 | 1 selects the small width |
| size_v_small | input | 1 | 1 selects the small height |
| hpos | input | 8 | window left column |
| vpos | input | 8 | window top row |
| vpos_rescale | input | 1 | scale vpos by 1.2 on long fields |
| frame_en | input | 1 | draw border |
| frame_own_color | input | 1 | border uses frame levels |
| frame_y | input | 4 | border luma level |
| frame_by | input | 3 | border B-Y level |
| frame_ry | input | 3 | border R-Y level |
| bg_en | input | 1 | fill window with levels |
| mute | input | 1 | force fill |
| bg_y | input | 4 | fill luma level |
| bg_by | input | 3 | fill B-Y level |
| bg_ry | input | 3 | fill R-Y level |
| moving | input | 1 | 1 lets new sub fields be written |
| pip_sw | output | 1 | window (picture or border) active |
| border_sel | output | 1 | border pixel |
| fill_sel | output | 1 | filled picture pixel |
| out_y | output | 4 | insert luma level |
| out_by | output | 3 | insert B-Y level |
| out_ry | output | 3 | insert R-Y level |
| rd_en | output | 1 | field memory read strobe |
| rd_x | output | $clog2(WID_L) | memory column |
| rd_y | output | $clog2(HGT_L) | memory row |
| mem_wr_en | output | 1 | sub field write allowed |

## Verification
A small raster (24 pixels by 12 lines) is swept over every combination of width and height size with origins at the left or top edge, in the middle, and near the right or bottom edge. These cases separate a correct size mux from swapped axes and show whether a border clipped at column 0 or a window running off the line wraps or stops. The border, fill, mute, own-colour and freeze settings are toggled across the sweep, so a wrong colour choice or a border that overlaps the picture shows up on individual pixels. Fields of 13 and 16 lines, with the rescale mode both on and off, show whether the 1.2 factor follows the length of the previous field. A field whose inputs change midway shows whether settings are captured on the field strobe. Line strobes sent before any field strobe check the state machine's wait state.

// File: rtl/pip_pkg.sv
package pip_pkg;
    localparam int POS_W = 8;
    localparam int VO_W  = POS_W + 1;
    localparam int Y_W   = 4;
    localparam int C_W   = 3;

    typedef enum logic [1:0] {
        FS_WAIT_VD = 2'd0,
        FS_ARMED   = 2'd1,
        FS_ACTIVE  = 2'd2
    } fstate_t;

    typedef struct packed {
        logic             disp_en;
        logic             size_h;
        logic             size_v;
        logic             frame_en;
        logic             frame_own;
        logic             bg_en;
        logic             mute;
        logic             moving;
        logic [POS_W-1:0] horg;
        logic [VO_W-1:0]  vorg;
        logic [Y_W-1:0]   bg_y;
        logic [C_W-1:0]   bg_by;
        logic [C_W-1:0]   bg_ry;
        logic [Y_W-1:0]   fr_y;
        logic [C_W-1:0]   fr_by;
        logic [C_W-1:0]   fr_ry;
    } cfg_t;
endpackage

// File: rtl/pip_raster_cnt.sv
module pip_raster_cnt
    import pip_pkg::*;
#(
    parameter int H_ACTIVE = 720,
    parameter int V_ACTIVE = 288,
    parameter int PXW      = 10,
    parameter int LNW      = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hd,
    input  logic           vd,
    output logic [PXW-1:0] pcnt,
    output logic [LNW-1:0] lcnt,
    output fstate_t        state
);
    fstate_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FS_WAIT_VD;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            FS_WAIT_VD: if (vd) nxt = hd ? FS_ACTIVE : FS_ARMED;
            FS_ARMED:   if (hd) nxt = FS_ACTIVE;
            FS_ACTIVE:  if (vd && !hd) nxt = FS_ARMED;
            default:    nxt = FS_WAIT_VD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= PXW'(H_ACTIVE);
            lcnt <= LNW'(V_ACTIVE);
        end else begin
            if (hd)                           pcnt <= '0;
            else if (pcnt < PXW'(H_ACTIVE))   pcnt <= pcnt + 1'b1;

            if (hd && (vd || state == FS_ARMED))
                lcnt <= '0;
            else if (vd)
                lcnt <= LNW'(V_ACTIVE);
            else if (hd && state == FS_ACTIVE && lcnt < LNW'(V_ACTIVE))
                lcnt <= lcnt + 1'b1;
        end
    end

    // R2: line strobe restarts the pixel count
    p_hd_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hd |=> pcnt == '0);
    // R2: pixel count steps by one until it stops at the line end
    p_pix_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hd && pcnt < PXW'(H_ACTIVE)) |=> pcnt == PXW'($past(pcnt) + 1'b1));
    // R2: line count never exceeds its stop value
    p_line_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lcnt <= LNW'(V_ACTIVE));
endmodule

// File: rtl/pip_cfg_latch.sv
module pip_cfg_latch
    import pip_pkg::*;
#(
    parameter int RATE_SPLIT = 287
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hd,
    input  logic vd,
    input  logic vmode,
    input  cfg_t raw,
    output cfg_t cfg_q
);
    localparam int FCW = $clog2(RATE_SPLIT + 2);

    logic [FCW-1:0]  hd_seen;
    logic            judged50;
    logic [VO_W+2:0] prod;
    logic [VO_W-1:0] scaled;

    always_comb begin
        judged50 = 32'(hd_seen) > RATE_SPLIT;
        prod     = (VO_W+3)'(raw.vorg) * (VO_W+3)'(6);
        scaled   = VO_W'(prod / (VO_W+3)'(5));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            hd_seen <= '0;
        end else if (vd) begin
            cfg_q      <= raw;
            cfg_q.vorg <= (vmode && judged50) ? scaled : raw.vorg;
            hd_seen    <= hd ? FCW'(1) : '0;
        end else if (hd && 32'(hd_seen) <= RATE_SPLIT) begin
            hd_seen <= hd_seen + 1'b1;
        end
    end

    // R11: settings hold between field strobes
    p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !vd |=> $stable(cfg_q));
    // R9: without the rescale mode the origin is taken as given
    p_vorg_plain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vd && !vmode) |=> cfg_q.vorg == $past(raw.vorg));
endmodule

// File: rtl/pip_window_cmp.sv
module pip_window_cmp
    import pip_pkg::*;
#(
    parameter int H_ACTIVE = 720,
    parameter int V_ACTIVE = 288,
    parameter int WID_L    = 229,
    parameter int WID_S    = 172,
    parameter int HGT_L    = 69,
    parameter int HGT_S    = 52,
    parameter int PXW      = 10,
    parameter int LNW      = 9,
    parameter int XAW      = 8,
    parameter int YAW      = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [PXW-1:0] pcnt,
    input  logic [LNW-1:0] lcnt,
    input  cfg_t           cfg,
    output logic           pip_sw,
    output logic           border_sel,
    output logic           fill_sel,
    output logic [Y_W-1:0] out_y,
    output logic [C_W-1:0] out_by,
    output logic [C_W-1:0] out_ry,
    output logic           rd_en,
    output logic [XAW-1:0] rd_x,
    output logic [YAW-1:0] rd_y
);
    localparam int CW = ((PXW > LNW ? PXW : LNW) > 10 ? (PXW > LNW ? PXW : LNW) : 10) + 2;

    logic [CW-1:0] x, y, x0, y0, x1, y1, wid, hgt;
    logic          live, pic, ring, show_pic, show_ring, filled;

    always_comb begin
        x    = CW'(pcnt);
        y    = CW'(lcnt);
        wid  = cfg.size_h ? CW'(WID_S) : CW'(WID_L);
        hgt  = cfg.size_v ? CW'(HGT_S) : CW'(HGT_L);
        x0   = CW'(cfg.horg);
        y0   = CW'(cfg.vorg);
        x1   = x0 + wid;
        y1   = y0 + hgt;
        live = (pcnt < PXW'(H_ACTIVE)) && (lcnt < LNW'(V_ACTIVE));
        pic  = live && x >= x0 && x < x1 && y >= y0 && y < y1;
        ring = live && cfg.frame_en && !pic &&
               (x + 1'b1) >= x0 && x <= x1 && (y + 1'b1) >= y0 && y <= y1;
        show_pic  = cfg.disp_en && pic;
        show_ring = cfg.disp_en && ring;
        filled    = show_pic && (cfg.bg_en || cfg.mute);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pip_sw     <= 1'b0;
            border_sel <= 1'b0;
            fill_sel   <= 1'b0;
            out_y      <= '0;
            out_by     <= '0;
            out_ry     <= '0;
            rd_en      <= 1'b0;
            rd_x       <= '0;
            rd_y       <= '0;
        end else begin
            pip_sw     <= show_pic || show_ring;
            border_sel <= show_ring;
            fill_sel   <= filled;
            rd_en      <= show_pic;
            rd_x       <= show_pic ? XAW'(x - x0) : '0;
            rd_y       <= show_pic ? YAW'(y - y0) : '0;
            if (show_ring && cfg.frame_own) begin
                out_y  <= cfg.fr_y;
                out_by <= cfg.fr_by;
                out_ry <= cfg.fr_ry;
            end else if (show_ring || filled) begin
                out_y  <= cfg.bg_y;
                out_by <= cfg.bg_by;
                out_ry <= cfg.bg_ry;
            end else begin
                out_y  <= '0;
                out_by <= '0;
                out_ry <= '0;
            end
        end
    end

    // R5: border and fill never overlap
    p_ring_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(border_sel && fill_sel));
    // R8: read addresses stay inside the largest stored field
    p_rd_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (32'(rd_x) < WID_L && 32'(rd_y) < HGT_L));
    // R10: the switch only opens inside the active raster
    p_clip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pip_sw |-> ($past(pcnt) < PXW'(H_ACTIVE) && $past(lcnt) < LNW'(V_ACTIVE)));
endmodule

// File: rtl/pip_window_inserter.sv
module pip_window_inserter
    import pip_pkg::*;
#(
    parameter int H_ACTIVE   = 720,
    parameter int V_ACTIVE   = 288,
    parameter int WID_L      = 229,
    parameter int WID_S      = 172,
    parameter int HGT_L      = 69,
    parameter int HGT_S      = 52,
    parameter int RATE_SPLIT = 287,
    localparam int XAW = $clog2(WID_L),
    localparam int YAW = $clog2(HGT_L)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           main_hd,
    input  logic           main_vd,
    input  logic           disp_en,
    input  logic           size_h_small,
    input  logic           size_v_small,
    input  logic [7:0]     hpos,
    input  logic [7:0]     vpos,
    input  logic           vpos_rescale,
    input  logic           frame_en,
    input  logic           frame_own_color,
    input  logic [3:0]     frame_y,
    input  logic [2:0]     frame_by,
    input  logic [2:0]     frame_ry,
    input  logic           bg_en,
    input  logic           mute,
    input  logic [3:0]     bg_y,
    input  logic [2:0]     bg_by,
    input  logic [2:0]     bg_ry,
    input  logic           moving,
    output logic           pip_sw,
    output logic           border_sel,
    output logic           fill_sel,
    output logic [3:0]     out_y,
    output logic [2:0]     out_by,
    output logic [2:0]     out_ry,
    output logic           rd_en,
    output logic [XAW-1:0] rd_x,
    output logic [YAW-1:0] rd_y,
    output logic           mem_wr_en
);
    localparam int PXW = $clog2(H_ACTIVE + 1);
    localparam int LNW = $clog2(V_ACTIVE + 1);

    logic [PXW-1:0] pcnt;
    logic [LNW-1:0] lcnt;
    fstate_t        state;
    cfg_t           raw, cfg;

    always_comb begin
        raw.disp_en   = disp_en;
        raw.size_h    = size_h_small;
        raw.size_v    = size_v_small;
        raw.frame_en  = frame_en;
        raw.frame_own = frame_own_color;
        raw.bg_en     = bg_en;
        raw.mute      = mute;
        raw.moving    = moving;
        raw.horg      = hpos;
        raw.vorg      = {1'b0, vpos};
        raw.bg_y      = bg_y;
        raw.bg_by     = bg_by;
        raw.bg_ry     = bg_ry;
        raw.fr_y      = frame_y;
        raw.fr_by     = frame_by;
        raw.fr_ry     = frame_ry;
    end

    pip_raster_cnt #(.H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .PXW(PXW), .LNW(LNW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .hd(main_hd), .vd(main_vd),
        .pcnt(pcnt), .lcnt(lcnt), .state(state)
    );

    pip_cfg_latch #(.RATE_SPLIT(RATE_SPLIT)) u_latch (
        .clk(clk), .rst_n(rst_n), .hd(main_hd), .vd(main_vd),
        .vmode(vpos_rescale), .raw(raw), .cfg_q(cfg)
    );

    pip_window_cmp #(
        .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .WID_L(WID_L), .WID_S(WID_S),
        .HGT_L(HGT_L), .HGT_S(HGT_S), .PXW(PXW), .LNW(LNW), .XAW(XAW), .YAW(YAW)
    ) u_cmp (
        .clk(clk), .rst_n(rst_n), .pcnt(pcnt), .lcnt(lcnt), .cfg(cfg),
        .pip_sw(pip_sw), .border_sel(border_sel), .fill_sel(fill_sel),
        .out_y(out_y), .out_by(out_by), .out_ry(out_ry),
        .rd_en(rd_en), .rd_x(rd_x), .rd_y(rd_y)
    );

    assign mem_wr_en = cfg.moving;

    // R1: no window while waiting for the first field strobe
    p_wait_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_WAIT_VD) |=> !pip_sw);
    // R12: write permission only changes on a field strobe
    p_wr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !main_vd |=> $stable(mem_wr_en));
endmodule

// File: tb/tb_pip_window_inserter.sv
module tb_pip_window_inserter;
    localparam int HA = 24, VA = 12, WL = 9, WS = 6, HL = 5, HS = 3, RS = 14;
    localparam int LC = HA + 4;

    logic clk = 0, rst_n = 0, main_hd = 0, main_vd = 0;
    logic disp_en = 0, size_h_small = 0, size_v_small = 0, vpos_rescale = 0;
    logic [7:0] hpos = 0, vpos = 0;
    logic frame_en = 0, frame_own_color = 0, bg_en = 0, mute = 0, moving = 0;
    logic [3:0] frame_y = 4'd9, bg_y = 4'd6;
    logic [2:0] frame_by = 3'd5, frame_ry = 3'd2, bg_by = 3'd3, bg_ry = 3'd7;
    logic pip_sw, border_sel, fill_sel, rd_en, mem_wr_en;
    logic [3:0] out_y;
    logic [2:0] out_by, out_ry;
    logic [3:0] rd_x;
    logic [2:0] rd_y;

    always #5 clk = ~clk;

    pip_window_inserter #(.H_ACTIVE(HA), .V_ACTIVE(VA), .WID_L(WL), .WID_S(WS),
        .HGT_L(HL), .HGT_S(HS), .RATE_SPLIT(RS)) dut (.*);

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    bit started = 0;
    int line = -1, hd_cnt = 0;
    bit l_disp, l_sh, l_sv, l_fr, l_fo, l_bg, l_mu, l_mv;
    int l_h, l_v;

    task automatic chk(string tag, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic pulse_vd();
        bit judged;
        @(negedge clk) main_vd = 1;
        @(posedge clk);
        @(negedge clk) main_vd = 0;
        judged = hd_cnt > RS;
        l_disp = disp_en; l_sh = size_h_small; l_sv = size_v_small;
        l_fr = frame_en; l_fo = frame_own_color; l_bg = bg_en; l_mu = mute; l_mv = moving;
        l_h = hpos;
        l_v = (vpos_rescale && judged) ? (int'(vpos) * 6) / 5 : int'(vpos);
        hd_cnt = 0; started = 1; line = -1;
    endtask

    task automatic check_pixel(int k, string tag);
        bit live, pic, ring, e_sw, e_b, e_f, e_rd;
        int w, h, ey, eby, ery;
        w = l_sh ? WS : WL;
        h = l_sv ? HS : HL;
        live = started && line >= 0 && line < VA && k < HA;
        pic  = live && k >= l_h && k < l_h + w && line >= l_v && line < l_v + h;
        ring = live && l_fr && !pic && k + 1 >= l_h && k <= l_h + w &&
               line + 1 >= l_v && line <= l_v + h;
        e_sw = l_disp && (pic || ring);
        e_b  = l_disp && ring;
        e_f  = l_disp && pic && (l_bg || l_mu);
        e_rd = l_disp && pic;
        if (e_b && l_fo) begin ey = 9; eby = 5; ery = 2; end
        else if (e_b || e_f) begin ey = 6; eby = 3; ery = 7; end
        else begin ey = 0; eby = 0; ery = 0; end
        chk({tag, " R2 R3 R4 R10 pip_sw"}, pip_sw, e_sw);
        chk({tag, " R5 border_sel"}, border_sel, e_b);
        chk({tag, " R7 fill_sel"}, fill_sel, e_f);
        chk({tag, " R6 levels"}, {out_y, out_by, out_ry}, (ey << 6) | (eby << 3) | ery);
        chk({tag, " R8 rd_en"}, rd_en, e_rd);
        chk({tag, " R8 rd_x"}, rd_x, e_rd ? k - l_h : 0);
        chk({tag, " R8 rd_y"}, rd_y, e_rd ? line - l_v : 0);
    endtask

    task automatic run_line(string tag);
        @(negedge clk) main_hd = 1;
        @(posedge clk);
        @(negedge clk) main_hd = 0;
        hd_cnt++;
        if (started) line = (line < 0) ? 0 : ((line + 1 > VA) ? VA : line + 1);
        for (int k = 0; k < LC - 1; k++) begin
            @(posedge clk);
            @(negedge clk);
            check_pixel(k, tag);
        end
        chk({tag, " R12 mem_wr_en"}, mem_wr_en, started ? l_mv : 0);
    endtask

    task automatic run_field(int n, string tag);
        pulse_vd();
        for (int i = 0; i < n; i++) run_line(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int harr[4] = '{0, 3, 17, 22};
        int varr[3] = '{0, 4, 9};
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;
        @(negedge clk);
        // R1: reset state of every output
        chk("R1 reset pip_sw", pip_sw, 0);
        chk("R1 reset border", border_sel, 0);
        chk("R1 reset fill", fill_sel, 0);
        chk("R1 reset rd", {rd_en, rd_x, rd_y}, 0);
        chk("R1 reset wr", mem_wr_en, 0);
        // R1: line strobes before any field strobe
        disp_en = 1; frame_en = 1; moving = 1;
        run_line("R1 pre-field");
        run_line("R1 pre-field");

        // R3 R5 R7 R10 sweep over sizes and origins
        for (int sh = 0; sh < 2; sh++)
            for (int sv = 0; sv < 2; sv++)
                for (int hi = 0; hi < 4; hi++)
                    for (int vi = 0; vi < 3; vi++) begin
                        disp_en = 1; size_h_small = sh[0]; size_v_small = sv[0];
                        hpos = 8'(harr[hi]); vpos = 8'(varr[vi]);
                        frame_en = ((hi + vi) % 2) == 0;
                        frame_own_color = vi[0];
                        bg_en = (hi == 1);
                        mute = (hi == 2) && sv[0];
                        moving = (vi != 1);
                        vpos_rescale = 0;
                        run_field(13, "R3 sweep");
                    end

        // R4: display disabled
        disp_en = 0; frame_en = 1; bg_en = 1; hpos = 3; vpos = 2;
        run_field(13, "R4 display off");

        // R9: rescale follows the previous field length
        disp_en = 1; frame_en = 1; bg_en = 0; mute = 0;
        size_h_small = 0; size_v_small = 0; vpos_rescale = 1; vpos = 5; hpos = 4;
        run_field(16, "R9 after short field");
        run_field(16, "R9 after long field");
        vpos = 9;
        run_field(13, "R9 long clipped");
        vpos_rescale = 0; vpos = 5;
        run_field(13, "R9 mode off");

        // R11: mid-field changes wait for the next field strobe
        hpos = 3; vpos = 1; frame_en = 1; bg_en = 0; moving = 1;
        pulse_vd();
        for (int i = 0; i < 3; i++) run_line("R11 before change");
        hpos = 10; vpos = 0; size_h_small = 1; bg_en = 1; moving = 0; disp_en = 0;
        for (int i = 0; i < 10; i++) run_line("R11 after change");
        run_field(13, "R11 new field");

        finished = 1;
        summary();
        $finish;
    end
endmodule